// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a 256-byte serial EEPROM that answers as a slave on a two-wire bus. The bus clock and data lines are sampled by a fast system clock. The block pulls the data line low through an output-enable signal and never drives it high. Start and stop conditions frame every command. A device address byte selects the part by comparing against three strap inputs. An 8-bit word pointer then steers the reads and writes.

A write sends a word address and then data bytes. The data bytes collect in a 16-byte page buffer and wrap inside the current page. They reach the storage array only when a stop arrives and the write-protect input is low. A committed page starts an internal write cycle that lasts a set number of system clocks. During that cycle the part ignores its own address. A read streams bytes from the pointer onward for as long as the master acknowledges each one.

Top module: `eep_slave`

## Requirements
- R1: After reset the block does not pull SDA, every storage byte reads 0xFF and the word pointer is 0.
- R2: The device address byte is 1010 in bits 7..4, then the three strap bits in bits 3..1, then R/W in bit 0 (1 = read). The block acknowledges only an exact match. After a mismatch it leaves SDA released until the next start.
- R3: After a stop commits a page, the block refuses to acknowledge its device address for WR_CYCLES system clocks. After that it acknowledges again.
- R4: In a write, the byte after the device address loads the word pointer, and every later byte is acknowledged and buffered. The buffer is stored on stop. A stop with no data bytes stores nothing and starts no write cycle.
- R5: During a write the pointer advances only in its low 4 bits, so data wraps inside the current 16-byte page.
- R6: While write-protect is high at the stop, data bytes are still acknowledged, but no location changes and no write cycle starts.
- R7: A read sends data MSB first, changing SDA only while SCL is low. Each master acknowledge yields the byte at the next address, and the pointer wraps from 255 to 0.
- R8: A read with no preceding word address starts at the current pointer, which is one past the last byte read or written.
- R9: When the master does not acknowledge a read byte, the block releases SDA and ignores further clocks until a stop.
- R10: A repeated start discards bytes buffered earlier in the same transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Address strap inputs |
| wp_i | input | 1 | Write protect, high blocks all writes |

## Verification
The address comparator is swept over all eight strap codes and one wrong type code. Only the single matching code may be acknowledged, and a refused part must stay silent. Every location is written with an address-derived pattern, one full page at a time, and then read back in one long sequential read. This separates correct pointer handling from off-by-one or page-mixing faults. A short write near a page end, a protected write, a write aborted by a repeated start, and a read that crosses from 255 to 0 each isolate a single rule. Probing right after a commit, and again after the write cycle ends, distinguishes a correct busy window from a missing one.

// File: rtl/eep_pkg.sv
package eep_pkg;
   localparam logic [3:0] DEV_TYPE = 4'b1010;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RX,
      S_ACK,
      S_TX,
      S_RACK,
      S_HOLD
   } st_t;

   typedef enum logic [1:0] {
      K_DEV,
      K_WADDR,
      K_DATA
   } kind_t;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_p, sda_p, scl_n, sda_n;
   logic              scl_q, sda_q;

   if (STAGES == 1) begin : g_single
      assign scl_n = scl_i;
      assign sda_n = sda_i;
   end else begin : g_chain
      assign scl_n = {scl_p[STAGES-2:0], scl_i};
      assign sda_n = {sda_p[STAGES-2:0], sda_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= '1;
         sda_p <= '1;
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_p <= scl_n;
         sda_p <= sda_n;
         scl_q <= scl_p[STAGES-1];
         sda_q <= sda_p[STAGES-1];
      end
   end

   assign scl_lvl   = scl_p[STAGES-1];
   assign sda_lvl   = sda_p[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_q;
   assign scl_fall  = ~scl_lvl & scl_q;
   assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
   parameter int CYCLES = 5000,
   localparam int CW = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (start)     cnt <= CW'(CYCLES);
      else if (cnt != '0) cnt <= cnt - CW'(1);
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
   parameter int          MEM_BYTES  = 256,
   parameter int          PAGE_BYTES = 16,
   parameter logic [7:0]  ERASED     = 8'hFF,
   localparam int AW  = $clog2(MEM_BYTES),
   localparam int PW  = $clog2(PAGE_BYTES),
   localparam int PGW = AW - PW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  rd_addr,
   output logic [7:0]     rd_data,
   input  logic           buf_we,
   input  logic [PW-1:0]  buf_idx,
   input  logic [7:0]     buf_data,
   input  logic           buf_clr,
   input  logic           commit,
   input  logic [PGW-1:0] commit_page,
   output logic           buf_any
);
   logic [7:0]            mem  [MEM_BYTES];
   logic [7:0]            pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem[i] <= ERASED;
      end else if (commit) begin
         for (int i = 0; i < PAGE_BYTES; i++)
            if (vld[i]) mem[{commit_page, PW'(i)}] <= pbuf[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld <= '0;
      else if (buf_clr) vld <= '0;
      else if (buf_we)  vld[buf_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (buf_we) pbuf[buf_idx] <= buf_data;
   end

   assign rd_data = mem[rd_addr];
   assign buf_any = |vld;
endmodule

// File: rtl/eep_slave.sv
module eep_slave
   import eep_pkg::*;
#(
   parameter int         MEM_BYTES   = 256,
   parameter int         PAGE_BYTES  = 16,
   parameter int         WR_CYCLES   = 5000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] ERASED      = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] strap_i,
   input  logic       wp_i
);
   localparam int AW  = $clog2(MEM_BYTES);
   localparam int PW  = $clog2(PAGE_BYTES);
   localparam int PGW = AW - PW;

   if ((1 << AW) != MEM_BYTES || AW > 8) begin : g_bad_mem
      $error("MEM_BYTES must be a power of two no larger than 256");
   end
   if ((1 << PW) != PAGE_BYTES || PAGE_BYTES >= MEM_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two below MEM_BYTES");
   end
   if (WR_CYCLES < 1) begin : g_bad_wr
      $error("WR_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic busy, commit, buf_any, buf_we, buf_clr;
   logic [7:0] rd_data;

   st_t        st;
   kind_t      kind;
   logic [3:0] bitcnt;
   logic [7:0] shreg, txreg;
   logic [AW-1:0] ptr;
   logic       rw, oe_q, wr_mode;
   logic       dev_hit, byte_end;

   eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   eep_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
   );

   eep_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .ERASED(ERASED)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_addr(ptr), .rd_data(rd_data),
      .buf_we(buf_we), .buf_idx(ptr[PW-1:0]), .buf_data(shreg),
      .buf_clr(buf_clr), .commit(commit), .commit_page(ptr[AW-1:PW]),
      .buf_any(buf_any)
   );

   assign byte_end = scl_fall && (bitcnt == 4'd8);
   assign dev_hit  = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_i) && !busy;
   assign buf_we   = (st == S_RX) && byte_end && (kind == K_DATA) && !start_det && !stop_det;
   assign buf_clr  = start_det | stop_det;
   assign commit   = stop_det && wr_mode && buf_any && !wp_i;
   assign sda_oe   = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         kind    <= K_DEV;
         bitcnt  <= '0;
         shreg   <= '0;
         txreg   <= '0;
         ptr     <= '0;
         rw      <= 1'b0;
         oe_q    <= 1'b0;
         wr_mode <= 1'b0;
      end else if (start_det) begin
         st      <= S_RX;
         kind    <= K_DEV;
         bitcnt  <= '0;
         oe_q    <= 1'b0;
         wr_mode <= 1'b0;
      end else if (stop_det) begin
         st      <= S_IDLE;
         oe_q    <= 1'b0;
         wr_mode <= 1'b0;
      end else begin
         unique case (st)
            S_RX: begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_lvl};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_end) begin
                  bitcnt <= '0;
                  unique case (kind)
                     K_DEV: begin
                        if (dev_hit) begin
                           st   <= S_ACK;
                           oe_q <= 1'b1;
                           rw   <= shreg[0];
                        end else begin
                           st   <= S_HOLD;
                        end
                     end
                     K_WADDR: begin
                        ptr     <= shreg[AW-1:0];
                        wr_mode <= 1'b1;
                        st      <= S_ACK;
                        oe_q    <= 1'b1;
                     end
                     default: begin
                        ptr  <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
                        st   <= S_ACK;
                        oe_q <= 1'b1;
                     end
                  endcase
               end
            end
            S_ACK: begin
               if (scl_fall) begin
                  if (kind == K_DEV && rw) begin
                     oe_q   <= ~rd_data[7];
                     txreg  <= {rd_data[6:0], 1'b0};
                     bitcnt <= 4'd1;
                     ptr    <= ptr + AW'(1);
                     st     <= S_TX;
                  end else begin
                     oe_q <= 1'b0;
                     kind <= (kind == K_DEV) ? K_WADDR : K_DATA;
                     st   <= S_RX;
                  end
               end
            end
            S_TX: begin
               if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     oe_q <= 1'b0;
                     st   <= S_RACK;
                  end else begin
                     oe_q   <= ~txreg[7];
                     txreg  <= {txreg[6:0], 1'b0};
                     bitcnt <= bitcnt + 4'd1;
                  end
               end
            end
            S_RACK: begin
               if (scl_rise && sda_lvl) begin
                  st <= S_HOLD;
               end else if (scl_fall) begin
                  oe_q   <= ~rd_data[7];
                  txreg  <= {rd_data[6:0], 1'b0};
                  bitcnt <= 4'd1;
                  ptr    <= ptr + AW'(1);
                  st     <= S_TX;
               end
            end
            default: begin
               oe_q <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
   import eep_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input st_t   st,
   input kind_t kind,
   input logic  busy,
   input logic  commit,
   input logic  wp_i,
   input logic  stop_det,
   input logic  sda_oe,
   input logic  scl_lvl
);
   p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE || st == S_HOLD) |-> !sda_oe);

   p_no_addr_ack_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ACK && kind == K_DEV) |-> !busy);

   p_commit_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> busy);

   p_stop_returns_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (st == S_IDLE));

   p_protect_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wp_i |-> !commit);

   p_sda_moves_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl);
endmodule

bind eep_slave eep_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .kind(kind), .busy(busy),
   .commit(commit), .wp_i(wp_i), .stop_det(stop_det),
   .sda_oe(sda_oe), .scl_lvl(scl_lvl)
);

// File: tb/sim_eep_slave.sv
module sim_eep_slave;
   localparam int WR = 400;
   localparam int Q  = 4;
   localparam logic [2:0] STRAP = 3'b101;

   logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
   logic sda_oe, sda_line;
   int   checks = 0, fails = 0;
   bit   done = 1'b0;
   logic [7:0] got [256];

   assign sda_line = sda_m & ~sda_oe;
   always #4 clk = ~clk;

   eep_slave #(.WR_CYCLES(WR)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   function automatic logic [7:0] dev(bit rd);
      return {4'b1010, STRAP, rd};
   endfunction

   task automatic waitc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start;
      sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
      sda_m = 1'b0; waitc(Q); scl_m = 1'b0; waitc(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; waitc(Q); scl_m = 1'b1; waitc(Q);
      sda_m = 1'b1; waitc(Q);
   endtask

   task automatic put_bit(bit b);
      sda_m = b; waitc(Q); scl_m = 1'b1; waitc(2 * Q); scl_m = 1'b0; waitc(Q);
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
      b = sda_line; waitc(Q); scl_m = 1'b0; waitc(Q);
   endtask

   task automatic send(input logic [7:0] v, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic recv(output logic [7:0] v, input bit more);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(!more);
   endtask

   task automatic read_from(int a, int n);
      bit ack;
      bus_start; send(dev(0), ack); send(8'(a), ack);
      bus_start; send(dev(1), ack);
      for (int i = 0; i < n; i++) recv(got[i], i != n - 1);
      bus_stop;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      bit ack, b;
      logic [7:0] v;
      waitc(5);
      chk(sda_oe == 1'b0, "R1 sda released in reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      waitc(5);
      chk(sda_oe == 1'b0, "R1 sda released after reset", int'(sda_oe), 0);

      // R1 / R8: current-address read from pointer 0 returns erased value
      bus_start; send(dev(1), ack);
      chk(ack, "R1 address ack", int'(ack), 1);
      recv(v, 1'b0); bus_stop;
      chk(v == 8'hFF, "R1 erased byte", int'(v), 'hFF);

      // R2: sweep all strap codes, then a wrong type code
      for (int s = 0; s < 8; s++) begin
         bus_start; send({4'b1010, 3'(s), 1'b0}, ack);
         chk(ack == (3'(s) == STRAP), "R2 strap compare", int'(ack), int'(3'(s) == STRAP));
         if (!ack) begin
            send(8'h00, ack);
            chk(!ack, "R2 silent after mismatch", int'(ack), 0);
         end
         bus_stop;
      end
      bus_start; send({4'b1011, STRAP, 1'b0}, ack); bus_stop;
      chk(!ack, "R2 wrong type code", int'(ack), 0);

      // R4 / R3: fill every page with a pattern
      for (int p = 0; p < 16; p++) begin
         bus_start; send(dev(0), ack); send(8'(p * 16), ack);
         for (int i = 0; i < 16; i++) begin
            send(pat(p * 16 + i), ack);
            chk(ack, "R4 data byte ack", int'(ack), 1);
         end
         bus_stop;
         if (p == 0) begin
            bus_start; send(dev(0), ack); bus_stop;
            chk(!ack, "R3 nack during write cycle", int'(ack), 0);
            waitc(WR);
            bus_start; send(dev(0), ack); bus_stop;
            chk(ack, "R3 ack after write cycle", int'(ack), 1);
         end else begin
            waitc(WR + 20);
         end
      end

      // R4 / R7: sequential read of the whole array
      read_from(0, 256);
      for (int a = 0; a < 256; a++)
         chk(got[a] == pat(a), "R7 sequential readback", int'(got[a]), int'(pat(a)));

      // R4 / R7 / R8: dummy write sets pointer, current read wraps 255 -> 0
      bus_start; send(dev(0), ack); send(8'hFE, ack); bus_stop;
      bus_start; send(dev(0), ack); bus_stop;
      chk(ack, "R4 empty write starts no cycle", int'(ack), 1);
      bus_start; send(dev(1), ack);
      for (int i = 0; i < 3; i++) recv(got[i], i != 2);
      bus_stop;
      chk(got[0] == pat(254), "R8 current read start", int'(got[0]), int'(pat(254)));
      chk(got[1] == pat(255), "R7 byte 255", int'(got[1]), int'(pat(255)));
      chk(got[2] == pat(0), "R7 wrap to 0", int'(got[2]), int'(pat(0)));

      // R9 / R8: nack ends read, clocks are then ignored
      bus_start; send(dev(1), ack); recv(v, 1'b0);
      chk(v == pat(1), "R8 pointer after last read", int'(v), int'(pat(1)));
      for (int i = 0; i < 9; i++) begin
         get_bit(b);
         chk(b == 1'b1, "R9 released after nack", int'(b), 1);
      end
      bus_stop;

      // R5: write crossing the page end wraps to page start
      bus_start; send(dev(0), ack); send(8'h3E, ack);
      send(8'hC1, ack); send(8'hC2, ack); send(8'hC3, ack);
      bus_stop; waitc(WR + 20);
      read_from(8'h3E, 2);
      chk(got[0] == 8'hC1, "R5 first byte", int'(got[0]), 'hC1);
      chk(got[1] == 8'hC2, "R5 page end", int'(got[1]), 'hC2);
      read_from(8'h30, 2);
      chk(got[0] == 8'hC3, "R5 wrapped byte", int'(got[0]), 'hC3);
      chk(got[1] == pat(8'h31), "R5 untouched in page", int'(got[1]), int'(pat(8'h31)));
      read_from(8'h40, 1);
      chk(got[0] == pat(8'h40), "R5 next page untouched", int'(got[0]), int'(pat(8'h40)));

      // R6: protected write
      wp = 1'b1;
      bus_start; send(dev(0), ack); send(8'h50, ack);
      send(8'h00, ack);
      chk(ack, "R6 data acked while protected", int'(ack), 1);
      send(8'h01, ack); bus_stop;
      bus_start; send(dev(0), ack); bus_stop;
      chk(ack, "R6 no write cycle", int'(ack), 1);
      wp = 1'b0;
      read_from(8'h50, 2);
      chk(got[0] == pat(8'h50), "R6 location kept", int'(got[0]), int'(pat(8'h50)));
      chk(got[1] == pat(8'h51), "R6 location kept", int'(got[1]), int'(pat(8'h51)));

      // R10: repeated start drops buffered data
      bus_start; send(dev(0), ack); send(8'h10, ack); send(8'hAA, ack);
      bus_start; send(dev(1), ack); recv(v, 1'b0); bus_stop;
      chk(v == pat(8'h11), "R10 read after repeated start", int'(v), int'(pat(8'h11)));
      bus_start; send(dev(0), ack); bus_stop;
      chk(ack, "R10 no write cycle", int'(ack), 1);
      read_from(8'h10, 1);
      chk(got[0] == pat(8'h10), "R10 buffer discarded", int'(got[0]), int'(pat(8'h10)));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule